// File: doc/BRIEF.md
# Random Number Generator Register Front End

This block sits between a random number generator's entropy stream and a simple memory-mapped register bus. It collects a set of 32-bit words from the entropy stream into output registers and raises a ready flag once the set is complete. Software reads the words and then clears the ready flag. Clearing the flag starts the next fill.

A single status register does two jobs. Reading it reports ready and the seven sticky health alarms. Writing ones to it clears the chosen bits. A control register enables the generator and picks which alarms drive the level interrupt. A configuration register bounds each fill:

- No word is taken until a minimum number of cycles has passed.
- Ready is forced once a maximum number of cycles has passed.

The health tests themselves are outside this block. They reach it as one-cycle alarm pulses.

Top module: `rng_regfront`

## Requirements
- R1: The output words sit at byte offsets 0x00, 0x04, 0x08 and 0x0C. A read (`bus_rd` high for one cycle) returns the addressed register on `bus_rdata` after the next clock edge. `bus_rdata` holds that value until the next read.
- R2: After reset every register is zero. `bus_rdata`, `irq` and `ent_ready` are low, and the generator is disabled.
- R3: The status register at 0x10 holds ready in bit 0. Alarm bits sit as follows, each set by the named pulse input:

  | Status bit | Alarm | Set by |
  |---|---|---|
  | 1 | shutdown overflow | `alarm_pulse[0]` |
  | 2 | stuck output | `alarm_pulse[1]` |
  | 3 | noise | `alarm_pulse[2]` |
  | 4 | run | `alarm_pulse[3]` |
  | 5 | long run | `alarm_pulse[4]` |
  | 6 | poker | `alarm_pulse[5]` |
  | 7 | monobit | `alarm_pulse[6]` |

  Alarm bits stay set until software clears them.
- R4: Writing to 0x10 clears each status bit written as 1 and leaves bits written as 0 untouched. An alarm pulse in the same cycle as a clear of its bit leaves the bit set.
- R5: The control register at 0x14 holds the generator enable in bit 10 and the interrupt enables for status bits 7..1 in bits 7..1. All other bits read as zero.
- R6: The configuration register at 0x18 holds the maximum refill count in bits 31:16 and the minimum refill count in bits 7:0. All other bits read as zero.
- R7: `irq` is high in the cycle after any alarm status bit (7..1) is both set and enabled. Ready never drives `irq`.
- R8: A fill starts one cycle after the generator is enabled with ready clear. Cycles of a fill are counted from 0. `ent_ready` stays low while that count is below the minimum refill count.
- R9: Accepted stream words fill the output words in order, offset 0x00 first. Ready is set at the clock edge that accepts the fourth word.
- R10: With a nonzero maximum refill count, ready is set at the end of fill cycle number max-1 even if words are missing. Words not yet loaded keep their old values. A maximum of zero means no limit.
- R11: While the generator is disabled, no fill runs, `ent_ready` is low and the output words do not change.
- R12: Reads of any other offset, including unaligned offsets, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| ent_valid | input | 1 | Entropy stream word valid |
| ent_data | input | 32 | Entropy stream word |
| ent_ready | output | 1 | Block accepts a stream word this cycle |
| alarm_pulse | input | 7 | Health alarm pulses for status bits 7..1 |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: four output words, an 8-bit address and a 16-bit refill counter. It then sets the refill bounds at run time through the configuration register. A minimum of two cycles exposes the `ent_ready` hold-off. A minimum of ten against a maximum of three makes the maximum win, so a forced completion leaves every word unloaded. A per-cycle reference model follows each fill, clear and alarm under these settings and compares read data, `ent_ready` and `irq` on every clock.

// File: rtl/rng_regfront_pkg.sv
package rng_regfront_pkg;
  localparam int DATA_W      = 32;
  localparam int N_ALARM     = 7;
  localparam int STAT_W      = N_ALARM + 1;
  localparam int OFS_STAT    = 'h10;
  localparam int OFS_CTRL    = 'h14;
  localparam int OFS_CFG     = 'h18;
  localparam int CTRL_EN_BIT = 10;
  localparam int MAX_LSB     = 16;
endpackage

// File: rtl/rng_fill_ctrl.sv
module rng_fill_ctrl
  import rng_regfront_pkg::*;
#(
  parameter int N_WORDS = 4,
  parameter int CNT_W   = 16,
  parameter int MIN_W   = 8,
  localparam int IDX_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              ready_q,
  input  logic [MIN_W-1:0]  min_cyc,
  input  logic [CNT_W-1:0]  max_cyc,
  input  logic              ent_valid,
  input  logic [DATA_W-1:0] ent_data,
  output logic              ent_ready,
  output logic              fill_done,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_word
);
  logic              fill_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] word_q [N_WORDS];
  logic              accept, last_word, timeout;

  assign ent_ready = enable && fill_q && (cnt_q >= CNT_W'(min_cyc));
  assign accept    = ent_ready && ent_valid;
  assign last_word = accept && (idx_q == IDX_W'(N_WORDS - 1));
  assign timeout   = (max_cyc != '0) && ({1'b0, cnt_q} + 1'b1 >= {1'b0, max_cyc});
  assign fill_done = enable && fill_q && (last_word || timeout);
  assign rd_word   = word_q[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
    end else if (!enable) begin
      fill_q <= 1'b0;
    end else if (!fill_q) begin
      if (!ready_q) begin
        fill_q <= 1'b1;
        cnt_q  <= '0;
        idx_q  <= '0;
      end
    end else begin
      if (fill_done) fill_q <= 1'b0;
      if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
      if (accept) idx_q <= idx_q + 1'b1;
    end
  end

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) word_q[w] <= '0;
      else if (accept && idx_q == IDX_W'(w)) word_q[w] <= ent_data;
    end
  end

  assert_max_bound_R10: assert property (@(posedge clk) disable iff (rst)
    (fill_q && max_cyc != '0 && enable) |-> (cnt_q < max_cyc));
  assert_idle_when_off_R11: assert property (@(posedge clk) disable iff (rst)
    !enable |-> (!ent_ready && !fill_done));
endmodule

// File: rtl/rng_status.sv
module rng_status
  import rng_regfront_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] set_vec,
  input  logic [STAT_W-1:0] clr_vec,
  input  logic [N_ALARM-1:0] irq_en,
  output logic [STAT_W-1:0] stat_q,
  output logic              irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      irq    <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~clr_vec) | set_vec;
      irq    <= |(stat_q[STAT_W-1:1] & irq_en);
    end
  end

  assert_w1c_clear_R4: assert property (@(posedge clk) disable iff (rst)
    |(clr_vec & ~set_vec) |=> ((stat_q & $past(clr_vec & ~set_vec)) == '0));
  assert_pulse_wins_R4: assert property (@(posedge clk) disable iff (rst)
    |set_vec |=> ((stat_q & $past(set_vec)) == $past(set_vec)));
  assert_irq_source_R7: assert property (@(posedge clk) disable iff (rst)
    irq |-> |$past(stat_q[STAT_W-1:1]));
endmodule

// File: rtl/rng_regfront.sv
module rng_regfront
  import rng_regfront_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int N_WORDS = 4,
  parameter int CNT_W   = 16,
  parameter int MIN_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              ent_valid,
  input  logic [31:0]       ent_data,
  output logic              ent_ready,
  input  logic [6:0]        alarm_pulse,
  output logic              irq
);
  localparam int IDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;

  logic               en_q;
  logic [N_ALARM-1:0] ie_q;
  logic [CNT_W-1:0]   max_q;
  logic [MIN_W-1:0]   min_q;
  logic [STAT_W-1:0]  stat_q, clr_vec, set_vec;
  logic               fill_done;
  logic [DATA_W-1:0]  rd_word, rd_mux;
  logic               hit_word, hit_stat, hit_ctrl, hit_cfg;

  assign hit_word = (bus_addr[1:0] == 2'b00) && (32'(bus_addr >> 2) < N_WORDS);
  assign hit_stat = (32'(bus_addr) == OFS_STAT);
  assign hit_ctrl = (32'(bus_addr) == OFS_CTRL);
  assign hit_cfg  = (32'(bus_addr) == OFS_CFG);

  assign clr_vec = (bus_wr && hit_stat) ? bus_wdata[STAT_W-1:0] : '0;
  assign set_vec = {alarm_pulse, fill_done};

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      ie_q  <= '0;
      max_q <= '0;
      min_q <= '0;
    end else if (bus_wr) begin
      if (hit_ctrl) begin
        en_q <= bus_wdata[CTRL_EN_BIT];
        ie_q <= bus_wdata[STAT_W-1:1];
      end
      if (hit_cfg) begin
        max_q <= bus_wdata[MAX_LSB +: CNT_W];
        min_q <= bus_wdata[MIN_W-1:0];
      end
    end
  end

  rng_status u_status (
    .clk     (clk),
    .rst     (rst),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .irq_en  (ie_q),
    .stat_q  (stat_q),
    .irq     (irq)
  );

  rng_fill_ctrl #(
    .N_WORDS (N_WORDS),
    .CNT_W   (CNT_W),
    .MIN_W   (MIN_W)
  ) u_fill (
    .clk       (clk),
    .rst       (rst),
    .enable    (en_q),
    .ready_q   (stat_q[0]),
    .min_cyc   (min_q),
    .max_cyc   (max_q),
    .ent_valid (ent_valid),
    .ent_data  (ent_data),
    .ent_ready (ent_ready),
    .fill_done (fill_done),
    .rd_idx    (bus_addr[IDX_W+1:2]),
    .rd_word   (rd_word)
  );

  always_comb begin
    rd_mux = '0;
    if (hit_word)      rd_mux = rd_word;
    else if (hit_stat) rd_mux = DATA_W'(stat_q);
    else if (hit_ctrl) rd_mux = DATA_W'({en_q, 2'b00, ie_q, 1'b0});
    else if (hit_cfg)  rd_mux = (DATA_W'(max_q) << MAX_LSB) | DATA_W'(min_q);
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assert_ready_from_fill_R9: assert property (@(posedge clk) disable iff (rst)
    (!stat_q[0] && !$past(rst)) ##1 stat_q[0] |-> $past(fill_done));
  assert_rdata_held_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_rd) |-> $stable(bus_rdata));
endmodule

// File: tb/rng_regfront_test.sv
module rng_regfront_test;
  localparam logic [31:0] BASE = 32'hC0DE_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        ent_valid = 1'b0;
  logic [31:0] ent_data = BASE;
  logic        ent_ready;
  logic [6:0]  alarm_pulse = '0;
  logic        irq;

  int n_tests = 0, n_fail = 0;

  always #10 clk = ~clk;

  rng_regfront uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ent_valid(ent_valid),
    .ent_data(ent_data), .ent_ready(ent_ready), .alarm_pulse(alarm_pulse), .irq(irq)
  );

  // reference model state
  logic [31:0] m_word [4];
  logic        m_ready, m_en, m_fill, m_irq;
  logic [6:0]  m_alarm, m_ie;
  logic [15:0] m_max, m_cnt;
  logic [7:0]  m_min;
  int          m_idx, m_total;
  logic [31:0] m_rdata;

  function automatic logic [31:0] model_read(input logic [7:0] a);
    if (a[1:0] == 2'b00 && a < 8'h10) return m_word[a[3:2]];
    if (a == 8'h10) return {24'h0, m_alarm, m_ready};
    if (a == 8'h14) return {21'h0, m_en, 2'b00, m_ie, 1'b0};
    if (a == 8'h18) return {m_max, 8'h00, m_min};
    return 32'h0;
  endfunction

  function automatic logic model_ent_ready();
    return m_en && m_fill && (m_cnt >= 16'(m_min)) && (m_idx < 4);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) m_word[i] = '0;
      m_ready = 0; m_en = 0; m_fill = 0; m_irq = 0; m_alarm = '0; m_ie = '0;
      m_max = '0; m_min = '0; m_cnt = '0; m_idx = 0; m_total = 0; m_rdata = '0;
    end else begin
      logic        acc, n_ready, n_fill, n_en;
      logic [6:0]  n_alarm, n_ie;
      logic [15:0] n_max, n_cnt;
      logic [7:0]  n_min;
      int          n_idx;
      acc = model_ent_ready() && ent_valid;
      if (bus_rd) m_rdata = model_read(bus_addr);
      n_alarm = m_alarm; n_ready = m_ready;
      if (bus_wr && bus_addr == 8'h10) begin
        n_alarm = n_alarm & ~bus_wdata[7:1];
        n_ready = n_ready & ~bus_wdata[0];
      end
      n_alarm = n_alarm | alarm_pulse;
      n_fill = m_fill; n_cnt = m_cnt; n_idx = m_idx;
      if (!m_en) n_fill = 0;
      else if (!m_fill) begin
        if (!m_ready) begin n_fill = 1; n_cnt = 0; n_idx = 0; end
      end else begin
        if (acc) begin m_word[m_idx] = ent_data; n_idx = m_idx + 1; m_total++; end
        if (m_cnt != 16'hFFFF) n_cnt = m_cnt + 1;
        if (n_idx == 4 || (m_max != 0 && 32'(m_cnt) + 1 >= 32'(m_max))) begin
          n_fill = 0; n_ready = 1;
        end
      end
      m_irq = |(m_alarm & m_ie);
      n_en = m_en; n_ie = m_ie; n_max = m_max; n_min = m_min;
      if (bus_wr && bus_addr == 8'h14) begin n_en = bus_wdata[10]; n_ie = bus_wdata[7:1]; end
      if (bus_wr && bus_addr == 8'h18) begin n_max = bus_wdata[31:16]; n_min = bus_wdata[7:0]; end
      m_alarm = n_alarm; m_ready = n_ready; m_fill = n_fill; m_cnt = n_cnt; m_idx = n_idx;
      m_en = n_en; m_ie = n_ie; m_max = n_max; m_min = n_min;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check("R1 rdata vs model", bus_rdata, m_rdata);
      check("R7 irq vs model", 32'(irq), 32'(m_irq));
      check("R8 ent_ready vs model", 32'(ent_ready), 32'(model_ent_ready()));
    end
  end

  // entropy stream: each word is BASE plus the count accepted so far
  initial forever begin
    @(negedge clk);
    ent_data = BASE + 32'(m_total);
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0;
    check(req, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    check("R2 rdata after reset", bus_rdata, 32'h0);
    check("R2 irq after reset", 32'(irq), 32'h0);
    check("R2 ent_ready after reset", 32'(ent_ready), 32'h0);
    rd(8'h10, 32'h0, "R2 status reset");
    rd(8'h14, 32'h0, "R2 control reset");
    rd(8'h18, 32'h0, "R2 config reset");
    rd(8'h00, 32'h0, "R2 word0 reset");
    ent_valid = 1;
    idle(5);
    check("R11 no accept while disabled", 32'(m_total), 32'h0);
    wr(8'h18, 32'hFFFF_FF03);
    rd(8'h18, 32'hFFFF_0003, "R6 config fields");
    wr(8'h18, 32'h0000_0002);
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, 32'h0000_04FE, "R5 control fields");
    idle(20);
    rd(8'h10, 32'h0000_0001, "R9 ready after fill");
    for (int i = 0; i < 4; i++) rd(8'(4 * i), BASE + 32'(i), "R9 word order fill1");
    // acknowledge ready, next fill
    wr(8'h10, 32'h0000_0001);
    rd(8'h10, 32'h0000_0000, "R4 ready cleared by ack");
    idle(20);
    for (int i = 0; i < 4; i++) rd(8'(4 * i), BASE + 32'(4 + i), "R1 words fill2");
    rd(8'h10, 32'h0000_0001, "R9 ready after fill2");
    // alarms
    @(negedge clk); alarm_pulse = 7'b100_0001;
    @(negedge clk); alarm_pulse = '0;
    rd(8'h10, 32'h0000_0083, "R3 alarm bit positions");
    check("R7 irq on enabled alarm", 32'(irq), 32'h1);
    wr(8'h14, 32'h0000_0400);
    idle(2);
    check("R7 irq masked", 32'(irq), 32'h0);
    rd(8'h10, 32'h0000_0083, "R3 alarms sticky");
    wr(8'h10, 32'h0000_0002);
    rd(8'h10, 32'h0000_0081, "R4 w1c single bit");
    @(negedge clk); bus_wr = 1; bus_addr = 8'h10; bus_wdata = 32'h80; alarm_pulse = 7'b100_0000;
    @(negedge clk); bus_wr = 0; alarm_pulse = '0;
    rd(8'h10, 32'h0000_0081, "R4 pulse beats clear");
    wr(8'h10, 32'h0000_0000);
    rd(8'h10, 32'h0000_0081, "R4 zero write no effect");
    wr(8'h14, 32'h0000_0480);
    idle(2);
    check("R7 irq from monobit", 32'(irq), 32'h1);
    // max bound forces ready with no words taken
    wr(8'h18, 32'h0003_000A);
    wr(8'h10, 32'h0000_0001);
    idle(10);
    rd(8'h10, 32'h0000_0081, "R10 forced ready");
    rd(8'h04, BASE + 32'h5, "R10 words kept");
    check("R10 nothing accepted", 32'(m_total), 32'h8);
    // disabled: no refill
    wr(8'h14, 32'h0000_0000);
    wr(8'h18, 32'h0000_0000);
    wr(8'h10, 32'h0000_0001);
    idle(10);
    check("R11 ent_ready low when off", 32'(ent_ready), 32'h0);
    rd(8'h10, 32'h0000_0080, "R11 no ready when off");
    rd(8'h0C, BASE + 32'h7, "R11 words unchanged");
    rd(8'h1C, 32'h0, "R12 unmapped 0x1C");
    rd(8'h40, 32'h0, "R12 unmapped 0x40");
    rd(8'h01, 32'h0, "R12 unaligned 0x01");
    rd(8'h12, 32'h0, "R12 unaligned 0x12");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule